// File: doc/BRIEF.md
# Dual Interval Timer with Identification Bank

This block holds two down-counting interval timers behind one 4 KB register window. A simple single-cycle bus with separate read and write strobes reaches either timer through a fixed address split. Both timers share one local register layout, so software drives them with the same code and a different base offset. The masked interrupts of the two timers are ORed onto one interrupt line. An eight-word identification bank at the top of the window is read-only. The integration-test offsets and every other unmapped offset read as zero.

Each timer has its own tick-enable input, so the two can count at different rates taken from the same clock. The control word of each timer selects the run state, the reload mode (periodic, one-shot or free-running), the counter size (16 or 32 bits), a tick prescaler (1, 16 or 256) and the interrupt enable. Loading a value restarts the count at once. A background load changes only the reload value.

Top module: `dual_timer_id`

## Requirements
- R1: Offsets 0x000–0x01F reach timer 0 and offsets 0x020–0x03F reach timer 1. Both use the same local map, taken from address bits [4:2]: 0x00 load, 0x04 current value, 0x08 control, 0x0C interrupt clear, 0x10 raw interrupt, 0x14 masked interrupt, 0x18 background load. An access to one timer leaves the other unchanged.
- R2: After reset each control register reads 0x20, the interrupt enable alone. Each load register reads 0, each value reads 0xFFFFFFFF, both raw interrupts read 0 and the interrupt output is low.
- R3: Offsets 0xFE0, 0xFE4, … 0xFFC return the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], in that order, with the upper bits zero.
- R4: Reads of the test offsets 0xF00 and 0xF04, of any other offset outside the timer and identification ranges, and of an unused local offset inside a timer all return zero.
- R5: Writes at offset 0x040 or above, including the identification bank, change no register and no count.
- R6: Read data appears on the clock edge after the one that samples the read strobe, and it then holds until the next read. A write takes effect on the edge that samples it, so a read in the next cycle returns the new value.
- R7: Control bit 7 runs the counter. While it runs, each qualified tick lowers the count by one. The tick that brings the count to zero sets the raw interrupt. In periodic mode (bit 6) the next qualified tick reloads the load value.
- R8: With bits 0 and 6 both clear the timer runs free: after zero it reloads 0xFFFF when bit 1 is 0 (16-bit counter) or 0xFFFFFFFF when bit 1 is 1 (32-bit counter).
- R9: In one-shot mode (bit 0) the count stops at zero after the one interrupt and stays there.
- R10: Control bits [3:2] divide the timer's tick-enable pulses by 1 (0), 16 (1) or 256 (2). Writing the control register restarts the divider. A stopped timer, or a timer whose tick enable is low, keeps its count.
- R11: Any write to the interrupt-clear offset clears the raw interrupt. The masked interrupt reads the raw interrupt ANDed with control bit 5. The interrupt output is the OR of both masked interrupts.
- R12: A write to the load offset sets both the load value and the count. A write to the background-load offset sets only the load value. Writes to the value offset are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 32 | Write data |
| tick_en | input | 2 | Per-timer count enable, bit i for timer i |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
The counting function is driven in periodic, one-shot and both free-running sizes. Each run stops exactly one tick before zero, at zero and one tick past zero, which separates an off-by-one in the interrupt point from a wrong reload source. Long tick bursts with the divide-by-16 and divide-by-256 settings on timer 1, with timer 0 left enabled but without ticks, separate prescaler errors from cross-talk between the two timers. Writes aimed at the identification bank and at aliases above 0x040 show whether decoding leaks into either timer.

// File: rtl/dt_pkg.sv
package dt_pkg;

  localparam int unsigned LOC_W = 3;

  localparam logic [LOC_W-1:0] LOC_LOAD   = 3'd0;
  localparam logic [LOC_W-1:0] LOC_VALUE  = 3'd1;
  localparam logic [LOC_W-1:0] LOC_CTRL   = 3'd2;
  localparam logic [LOC_W-1:0] LOC_ICLR   = 3'd3;
  localparam logic [LOC_W-1:0] LOC_RAW    = 3'd4;
  localparam logic [LOC_W-1:0] LOC_MSK    = 3'd5;
  localparam logic [LOC_W-1:0] LOC_BGLOAD = 3'd6;

  // control word bit positions (software visible)
  localparam int unsigned CB_SINGLE = 0;
  localparam int unsigned CB_WIDE   = 1;
  localparam int unsigned CB_PRE_LO = 2;
  localparam int unsigned CB_IE     = 5;
  localparam int unsigned CB_PERIOD = 6;
  localparam int unsigned CB_RUN    = 7;
  localparam int unsigned CTRL_W    = 8;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h04;
      3'd1:    b = 8'h18;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dt_reset_sync.sv
module dt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int unsigned MID_BITS  = 4,
  parameter int unsigned HIGH_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       tick_in,
  input  logic [1:0] sel,
  output logic       tick_out
);
  localparam logic [MID_BITS-1:0]  MID_TOP  = '1;
  localparam logic [HIGH_BITS-1:0] HIGH_TOP = '1;

  logic [HIGH_BITS-1:0] pc_q, pc_d;
  logic                 adv;
  logic                 wrap;

  always_comb begin
    adv = run & tick_in;
    case (sel)
      2'd1:    wrap = (pc_q[MID_BITS-1:0] == MID_TOP);
      2'd2:    wrap = (pc_q == HIGH_TOP);
      default: wrap = 1'b1;
    endcase
    tick_out = adv & wrap;
    pc_d = pc_q;
    if (clr)      pc_d = '0;
    else if (adv) pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/dt_timer_core.sv
module dt_timer_core
  import dt_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LOC_W-1:0] loc,
  input  logic [W-1:0]     wdata,
  input  logic             tick_in,
  output logic [W-1:0]     rdata,
  output logic             irq
);
  localparam logic [W-1:0] MAX_WIDE   = '1;
  localparam logic [W-1:0] MAX_NARROW = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [W-1:0]      load_q, load_d;
  logic [W-1:0]      cnt_q,  cnt_d;
  logic              raw_q,  raw_d;

  logic          wide, single, reloads, step, at_zero, hit, ld_wr;
  logic [W-1:0]  cnt_eff, reload_v, dec_v;

  dt_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr && (loc == LOC_CTRL)),
    .run      (ctrl_q[CB_RUN]),
    .tick_in  (tick_in),
    .sel      (ctrl_q[CB_PRE_LO+1:CB_PRE_LO]),
    .tick_out (step)
  );

  always_comb begin
    wide    = ctrl_q[CB_WIDE];
    single  = ctrl_q[CB_SINGLE];
    reloads = ctrl_q[CB_PERIOD] | single;
    ld_wr   = wr && (loc == LOC_LOAD);
    cnt_eff = wide ? cnt_q : (cnt_q & MAX_NARROW);
    at_zero = (cnt_eff == '0);
    dec_v   = wide ? (cnt_q - 1'b1) : ((cnt_q - 1'b1) & MAX_NARROW);
    if (reloads) reload_v = wide ? load_q : (load_q & MAX_NARROW);
    else         reload_v = wide ? MAX_WIDE : MAX_NARROW;
    hit     = step && !ld_wr && (cnt_eff == {{(W-1){1'b0}}, 1'b1});

    cnt_d = cnt_q;
    if (ld_wr)                       cnt_d = wdata;
    else if (step && !at_zero)       cnt_d = dec_v;
    else if (step && !single)        cnt_d = reload_v;

    load_d = load_q;
    if (wr && (loc == LOC_LOAD || loc == LOC_BGLOAD)) load_d = wdata;

    ctrl_d = ctrl_q;
    if (wr && loc == LOC_CTRL) ctrl_d = wdata[CTRL_W-1:0];

    raw_d = raw_q;
    if (hit)                         raw_d = 1'b1;
    else if (wr && loc == LOC_ICLR)  raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      load_q <= '0;
      cnt_q  <= MAX_WIDE;
      raw_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
      raw_q  <= raw_d;
    end
  end

  always_comb begin
    case (loc)
      LOC_LOAD, LOC_BGLOAD: rdata = load_q;
      LOC_VALUE:            rdata = cnt_q;
      LOC_CTRL:             rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
      LOC_RAW:              rdata = {{(W-1){1'b0}}, raw_q};
      LOC_MSK:              rdata = {{(W-1){1'b0}}, raw_q & ctrl_q[CB_IE]};
      default:              rdata = '0;
    endcase
  end

  assign irq = raw_q & ctrl_q[CB_IE];

  // R7: the raw interrupt rises only as the count lands on zero
  a_r7_int_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> (cnt_q == '0));

  // R11: a clear write with no qualified tick leaves the raw flag low
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && loc == LOC_ICLR && !step) |=> !raw_q);

  // R9: a one-shot counter at zero stays there unless reloaded by software
  a_r9_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cnt_q == '0 && !ld_wr) |=> (cnt_q == '0));

  // R10: a stopped counter does not move
  a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_RUN] && !ld_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_timer_id.sv
module dual_timer_id
  import dt_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    tick_en,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int unsigned NT     = 2;
  localparam int unsigned SLOT_W = AW - 5;
  localparam logic [SLOT_W-1:0] ID_SLOT = '1;

  logic                 rst_i_n;
  logic [SLOT_W-1:0]    slot;
  logic [LOC_W-1:0]     loc;
  logic                 id_sel;
  logic [NT-1:0]        t_sel;
  logic [NT-1:0]        t_irq;
  logic [DW-1:0]        t_rdata [NT];
  logic [DW-1:0]        rd_mux;
  logic [DW-1:0]        rdata_q, rdata_d;

  dt_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign slot   = addr[AW-1:5];
  assign loc    = addr[4:2];
  assign id_sel = (slot == ID_SLOT);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign t_sel[i] = (slot == SLOT_W'(i));
    dt_timer_core #(.W(DW), .NW(NARROW_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr      (wr_en & t_sel[i]),
      .loc     (loc),
      .wdata   (wdata),
      .tick_in (tick_en[i]),
      .rdata   (t_rdata[i]),
      .irq     (t_irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (t_sel[0])    rd_mux = t_rdata[0];
    else if (t_sel[1]) rd_mux = t_rdata[1];
    else if (id_sel) rd_mux = {{(DW-8){1'b0}}, id_byte(loc)};
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
  assign irq   = |t_irq;

  // R4: reads between the timers and the ID bank return zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && addr >= AW'(12'h040) && addr < AW'(12'hFE0)) |=> (rdata == '0));

  // R3: the first identification word
  a_r3_first_id: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && addr == AW'(12'hFE0)) |=> (rdata == DW'(32'h04)));

  // R6: read data holds between reads
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/dual_timer_id_bench.sv
module dual_timer_id_bench;
  logic        clk, rst_n, wr_en, rd_en, irq;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [1:0]  tick_en;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  logic pend = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  dual_timer_id u_dual_timer_id (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tick_en(tick_en), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: compares each read one cycle after its strobe
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int which, input int n);
    tick_en[which] = 1'b1;
    repeat (n) @(negedge clk);
    tick_en[which] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; tick_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(12'h008, 32'h20, "R2 t0 ctrl");
    rd(12'h028, 32'h20, "R2 t1 ctrl");
    rd(12'h004, 32'hFFFF_FFFF, "R2 t0 value");
    rd(12'h000, 32'h0, "R2 t0 load");
    rd(12'h030, 32'h0, "R2 t1 raw");
    chk_irq(1'b0, "R2 irq");

    // R3 identification bank
    rd(12'hFE0, 32'h04, "R3 id0"); rd(12'hFE4, 32'h18, "R3 id1");
    rd(12'hFE8, 32'h14, "R3 id2"); rd(12'hFEC, 32'h00, "R3 id3");
    rd(12'hFF0, 32'h0D, "R3 id4"); rd(12'hFF4, 32'hF0, "R3 id5");
    rd(12'hFF8, 32'h05, "R3 id6"); rd(12'hFFC, 32'hB1, "R3 id7");

    // R4 zero reads
    rd(12'hF00, 32'h0, "R4 test ctrl");
    rd(12'hF04, 32'h0, "R4 test out");
    rd(12'h040, 32'h0, "R4 unmapped 0x040");
    rd(12'h800, 32'h0, "R4 unmapped 0x800");
    rd(12'h01C, 32'h0, "R4 unused local");

    // R7 periodic 32-bit on timer 0, load 5
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hE2);
    ticks(0, 4);
    rd(12'h004, 32'd1, "R7 one before zero");
    rd(12'h010, 32'd0, "R7 raw before zero");
    ticks(0, 1);
    rd(12'h004, 32'd0, "R7 at zero");
    rd(12'h010, 32'd1, "R7 raw at zero");
    rd(12'h014, 32'd1, "R11 masked set");
    chk_irq(1'b1, "R11 irq from t0");
    rd(12'h024, 32'hFFFF_FFFF, "R1 t1 untouched");
    ticks(0, 1);
    rd(12'h004, 32'd5, "R7 reload");

    // R11 mask and clear
    wr(12'h008, 32'hC2);
    chk_irq(1'b0, "R11 masked off");
    wr(12'h00C, 32'h0);
    rd(12'h010, 32'd0, "R11 cleared");
    ticks(0, 6);
    rd(12'h010, 32'd1, "R11 raw with ie off");
    rd(12'h014, 32'd0, "R11 masked with ie off");
    chk_irq(1'b0, "R11 irq with ie off");
    wr(12'h008, 32'hE2);
    chk_irq(1'b1, "R11 irq after ie on");
    wr(12'h00C, 32'h0);
    chk_irq(1'b0, "R11 irq after clear");

    // R10 prescaler on timer 1
    wr(12'h020, 32'h100);
    wr(12'h028, 32'hE6);
    ticks(1, 40);
    rd(12'h024, 32'hFE, "R10 div16");
    rd(12'h004, 32'd5, "R10 t0 without ticks");
    wr(12'h028, 32'hEA);
    ticks(1, 300);
    rd(12'h024, 32'hFD, "R10 div256");

    // R12 background load and value write
    wr(12'h038, 32'd7);
    rd(12'h024, 32'hFD, "R12 bgload keeps count");
    rd(12'h020, 32'd7, "R12 bgload sets load");
    wr(12'h024, 32'h1234);
    rd(12'h024, 32'hFD, "R12 value write ignored");
    wr(12'h020, 32'd9);
    rd(12'h024, 32'd9, "R6 write then read");

    // R9 one-shot on timer 1
    wr(12'h020, 32'd2);
    wr(12'h028, 32'hA3);
    ticks(1, 5);
    rd(12'h024, 32'd0, "R9 held at zero");
    rd(12'h030, 32'd1, "R9 raw set");
    chk_irq(1'b1, "R11 irq from t1");
    wr(12'h02C, 32'h0);
    chk_irq(1'b0, "R11 t1 cleared");

    // R8 free-running 16-bit then 32-bit on timer 0
    wr(12'h008, 32'h00);
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hA0);
    ticks(0, 4);
    rd(12'h004, 32'h0000_FFFF, "R8 narrow wrap");
    wr(12'h00C, 32'h0);
    wr(12'h000, 32'd1);
    wr(12'h008, 32'hA2);
    ticks(0, 2);
    rd(12'h004, 32'hFFFF_FFFF, "R8 wide wrap");
    wr(12'h008, 32'h20);
    ticks(0, 5);
    rd(12'h004, 32'hFFFF_FFFF, "R10 stopped holds");
    wr(12'h00C, 32'h0);

    // R5 writes at 0x040 and above
    wr(12'hFE0, 32'hFF);
    wr(12'h040, 32'h55);
    wr(12'h060, 32'h66);
    wr(12'h048, 32'hFF);
    wr(12'hF00, 32'h1);
    rd(12'hFE0, 32'h04, "R5 id unchanged");
    rd(12'h000, 32'd1, "R5 t0 load unchanged");
    rd(12'h008, 32'h20, "R5 t0 ctrl unchanged");
    rd(12'h028, 32'hA3, "R5 t1 ctrl unchanged");
    rd(12'h004, 32'hFFFF_FFFF, "R5 t0 value unchanged");

    // R6 hold between reads
    repeat (3) @(negedge clk);
    total++;
    if (rdata !== 32'hFFFF_FFFF) begin
      fails++;
      $display("FAIL R6 hold: actual %h expected %h", rdata, 32'hFFFF_FFFF);
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule